// File: doc/BRIEF.md
# Serial EEPROM Slave with Per-Block Write Protection

This block is the two-wire serial slave for a small EEPROM of two 256-byte pages. It handles plain memory writes, random and sequential reads, and a page-select command. It also holds four write-protect flags, one for each 128-byte quarter of the storage. A data byte written into a protected quarter is acknowledged on the bus but leaves the stored value unchanged.

The flags are changed or queried through their own device code. These commands take effect only while a digital high-voltage-detect input is high. To set or clear a flag, the master sends the command byte and two filler bytes. The change is applied at STOP, but only if the detect input was high at START and is still high at STOP. A query returns no data byte. The slave gives the answer in the acknowledge bit of the command byte.

SCL and SDA are sampled by the block clock through synchronisers. SDA is open drain: `sda_oe_o` pulls the line low.

Top module: `eeprom_wp_slave`

## Requirements
- R1: The upper nibble of the first byte after START selects the target: 1010 is memory, 0110 is a protect flag, 0111 is page select. Bit 0 is the read (1) or write (0) direction. Any other nibble is answered with NoACK.
- R2: A memory write sends the byte address and then data bytes. Each data byte is stored at the current page and address. The address then increments within the page, wrapping from 0xFF to 0x00 without changing the page.
- R3: A read returns the byte at the current address and then the following bytes, for as long as the master ACKs. After a master NoACK the slave releases SDA. A random read is a write of the byte address, then a repeated START, then a read command.
- R4: A page-select write (0111, bit 0 = 0) loads bit 1 of that byte as the page for all later memory accesses. The page is 0 after reset.
- R5: Protect block number = {page, byte address bit 7}. Blocks in one page are independent of each other and of the other page.
- R6: A data byte written into a block whose flag is set is still ACKed, and the stored byte keeps its old value.
- R7: In a flag write, byte bit 3 = 1 sets and 0 clears, and bits [2:1] give the block. The change commits at STOP only after exactly two filler bytes, whose values are ignored.
- R8: A flag command is NoACKed when the detect input was low at START. If the input falls before STOP, the pending change is discarded.
- R9: A flag read (0110, bit 0 = 1, bits [2:1] = block) with the detect input high is answered with NoACK when the flag is set and with ACK when it is clear.
- R10: After reset all flags are clear, the page is 0 and SDA is released.
- R11: The slave changes its SDA drive only after an SCL falling edge, a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the wire |
| hv_det_i | input | 1 | Qualifier from the external high-voltage detector |
| sda_oe_o | output | 1 | Pull SDA low when 1 |

## Verification
The assertions assume that the master changes SDA only while SCL is low, except for START and STOP. They also assume that every SCL phase lasts several block clocks, so the synchronised edges never merge. The bench holds each bus phase for ten clocks and moves the detect input only while SCL is low. The detect input is raised well before START and dropped well after STOP, except in the abort case, which drops it between two filler bytes.

// File: rtl/eeprom_wp_pkg.sv
package eeprom_wp_pkg;
  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} bus_st_e;
  typedef enum logic [2:0] {PH_DEV, PH_WADR, PH_WDAT, PH_FADR, PH_FDAT, PH_SKIP} byte_ph_e;
  localparam logic [3:0] DEV_MEM  = 4'b1010;
  localparam logic [3:0] DEV_FLAG = 4'b0110;
  localparam logic [3:0] DEV_PAGE = 4'b0111;
endpackage

// File: rtl/eeprom_wp_line.sv
module eeprom_wp_line #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic hv_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o,
  output logic sda_o,
  output logic hv_o
);
  logic [STAGES-1:0] scl_sr, sda_sr, hv_sr;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
      hv_sr  <= '0;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[STAGES-2:0], sda_i};
      hv_sr  <= {hv_sr[STAGES-2:0], hv_i};
      scl_q  <= scl_sr[STAGES-1];
      sda_q  <= sda_sr[STAGES-1];
    end
  end

  assign sda_o      = sda_sr[STAGES-1];
  assign hv_o       = hv_sr[STAGES-1];
  assign scl_rise_o = scl_sr[STAGES-1] & ~scl_q;
  assign scl_fall_o = ~scl_sr[STAGES-1] & scl_q;
  assign start_o    = scl_sr[STAGES-1] & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_sr[STAGES-1] & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/eeprom_wp_flags.sv
module eeprom_wp_flags #(
  parameter int BLK_W = 2,
  localparam int NBLK = 1 << BLK_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             hv_i,
  input  logic             load_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic             set_i,
  input  logic             dummy_i,
  output logic [NBLK-1:0]  flags_o,
  output logic             hv_ok_o
);
  logic             pend_q, pset_q;
  logic [BLK_W-1:0] pblk_q;
  logic [1:0]       dcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o <= '0;
      hv_ok_o <= 1'b0;
      pend_q  <= 1'b0;
      pset_q  <= 1'b0;
      pblk_q  <= '0;
      dcnt_q  <= '0;
    end else begin
      if (start_i) hv_ok_o <= hv_i;
      else if (!hv_i) hv_ok_o <= 1'b0;

      if (start_i) begin
        pend_q <= 1'b0;
        dcnt_q <= '0;
      end else if (stop_i) begin
        if (pend_q && dcnt_q == 2'd2 && hv_ok_o && hv_i) flags_o[pblk_q] <= pset_q;
        pend_q <= 1'b0;
      end else if (load_i) begin
        pend_q <= 1'b1;
        pblk_q <= blk_i;
        pset_q <= set_i;
        dcnt_q <= '0;
      end else if (dummy_i && dcnt_q != 2'd2) begin
        dcnt_q <= dcnt_q + 2'd1;
      end
    end
  end
endmodule

// File: rtl/eeprom_wp_mem.sv
module eeprom_wp_mem #(
  parameter int AW    = 9,
  parameter int BLK_W = 2,
  localparam int NBLK = 1 << BLK_W,
  localparam int DEPTH = 1 << AW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [7:0]      wdata_i,
  input  logic [NBLK-1:0] prot_i,
  output logic [7:0]      rdata_o
);
  logic [7:0]       mem [DEPTH];
  logic [BLK_W-1:0] blk;

  assign blk     = addr_i[AW-1 -: BLK_W];
  assign rdata_o = mem[addr_i];

  always_ff @(posedge clk_i) begin
    if (we_i && !prot_i[blk]) mem[addr_i] <= wdata_i;
  end

  // R6: a write request into a protected block leaves the cell as it was
  a_r6_protected_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && prot_i[blk]) |=> mem[$past(addr_i)] == $past(mem[addr_i]));
endmodule

// File: rtl/eeprom_wp_slave.sv
module eeprom_wp_slave
  import eeprom_wp_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic hv_det_i,
  output logic sda_oe_o
);
  localparam int BLK_W  = PAGE_W + 1;
  localparam int NBLK   = 1 << BLK_W;
  localparam int MEM_AW = ADDR_W + PAGE_W;

  logic scl_rise, scl_fall, start, stop, sda_s, hv_s;
  logic [NBLK-1:0] flags;
  logic hv_ok;

  bus_st_e  state;
  byte_ph_e phase, ev_ph;
  logic [3:0]        cnt;
  logic [7:0]        sh, tx_sh, rdata;
  logic [ADDR_W-1:0] adr_q;
  logic [PAGE_W-1:0] page_q;
  logic ack_q, rd_q, mack_q;
  logic byte_end, ev_ack, ev_rd, mem_we, f_load, f_dummy, page_we, adr_ld, tx_load, adr_inc;

  eeprom_wp_line #(.STAGES(SYNC_STAGES)) i_line (
    .clk_i, .rst_ni, .scl_i, .sda_i, .hv_i(hv_det_i),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall), .start_o(start),
    .stop_o(stop), .sda_o(sda_s), .hv_o(hv_s)
  );

  eeprom_wp_flags #(.BLK_W(BLK_W)) i_flags (
    .clk_i, .rst_ni, .start_i(start), .stop_i(stop), .hv_i(hv_s),
    .load_i(f_load), .blk_i(sh[BLK_W:1]), .set_i(sh[BLK_W+1]),
    .dummy_i(f_dummy), .flags_o(flags), .hv_ok_o(hv_ok)
  );

  eeprom_wp_mem #(.AW(MEM_AW), .BLK_W(BLK_W)) i_mem (
    .clk_i, .rst_ni, .we_i(mem_we), .addr_i({page_q, adr_q}),
    .wdata_i(sh), .prot_i(flags), .rdata_o(rdata)
  );

  assign byte_end = (state == S_RX) && scl_fall && (cnt == 4'd8);

  always_comb begin
    ev_ack = 1'b0; ev_ph = PH_SKIP; ev_rd = 1'b0;
    mem_we = 1'b0; f_load = 1'b0; f_dummy = 1'b0;
    page_we = 1'b0; adr_ld = 1'b0;
    if (byte_end) begin
      case (phase)
        PH_DEV: begin
          case (sh[7:4])
            DEV_MEM: begin
              ev_ack = 1'b1;
              ev_rd  = sh[0];
              ev_ph  = PH_WADR;
            end
            DEV_PAGE: begin
              ev_ack  = !sh[0];
              page_we = !sh[0];
            end
            DEV_FLAG: begin
              if (hv_ok) begin
                if (sh[0]) ev_ack = !flags[sh[BLK_W:1]];  // query answers via ACK
                else begin
                  ev_ack = 1'b1;
                  f_load = 1'b1;
                  ev_ph  = PH_FADR;
                end
              end
            end
            default: ;
          endcase
        end
        PH_WADR: begin ev_ack = 1'b1; adr_ld = 1'b1; ev_ph = PH_WDAT; end
        PH_WDAT: begin ev_ack = 1'b1; mem_we = 1'b1; ev_ph = PH_WDAT; end
        PH_FADR: begin ev_ack = 1'b1; f_dummy = 1'b1; ev_ph = PH_FDAT; end
        PH_FDAT: begin ev_ack = 1'b1; f_dummy = 1'b1; end
        default: ;
      endcase
    end
  end

  assign tx_load = scl_fall && ((state == S_ACK && ack_q && rd_q) || (state == S_MACK && mack_q));
  assign adr_inc = mem_we || tx_load;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state  <= S_IDLE;
      phase  <= PH_DEV;
      cnt    <= '0;
      sh     <= '0;
      tx_sh  <= '0;
      adr_q  <= '0;
      page_q <= '0;
      ack_q  <= 1'b0;
      rd_q   <= 1'b0;
      mack_q <= 1'b0;
    end else if (start) begin
      state <= S_RX;
      phase <= PH_DEV;
      cnt   <= '0;
      rd_q  <= 1'b0;
    end else if (stop) begin
      state <= S_IDLE;
    end else begin
      if (adr_ld) adr_q <= sh;
      else if (adr_inc) adr_q <= adr_q + 1'b1;  // wraps inside the page
      if (page_we) page_q <= sh[PAGE_W:1];
      case (state)
        S_RX: begin
          if (scl_rise && cnt < 4'd8) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (byte_end) begin
            state <= S_ACK;
            ack_q <= ev_ack;
            phase <= ev_ph;
            cnt   <= '0;
            if (phase == PH_DEV) rd_q <= ev_rd;
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            if (!ack_q) state <= S_IDLE;
            else if (rd_q) begin
              state <= S_TX;
              tx_sh <= rdata;
            end else state <= S_RX;
          end
        end
        S_TX: begin
          if (scl_fall) begin
            tx_sh <= {tx_sh[6:0], 1'b0};
            if (cnt == 4'd7) begin
              state <= S_MACK;
              cnt   <= '0;
            end else cnt <= cnt + 4'd1;
          end
        end
        S_MACK: begin
          if (scl_rise) mack_q <= !sda_s;
          else if (scl_fall) begin
            if (mack_q) begin
              state <= S_TX;
              tx_sh <= rdata;
            end else state <= S_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = (state == S_ACK && ack_q) || (state == S_TX && !tx_sh[7]);

  // R11: drive changes only follow SCL low edge or a bus condition
  a_r11_drive_timing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> $past(scl_fall || start || stop));

  // R8: flags move only on a STOP seen with the qualifier high
  a_r8_flag_change_at_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(flags) |-> $past(stop && hv_s));

  // R2: address wrap stays in the page
  a_r2_wrap_in_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adr_inc && !adr_ld && adr_q == '1) |=> (adr_q == '0) && $stable(page_q));

  // R1: unknown device code is not acknowledged
  a_r1_unknown_nack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_end && phase == PH_DEV && sh[7:4] != DEV_MEM && sh[7:4] != DEV_FLAG
     && sh[7:4] != DEV_PAGE) |=> !sda_oe_o);
endmodule

// File: tb/test_eeprom_wp_slave.sv
module test_eeprom_wp_slave;
  localparam int Q = 10;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, hv = 1'b0;
  logic sda_oe;
  logic sda_line;
  assign sda_line = sda_m & ~sda_oe;

  eeprom_wp_slave i_eeprom_wp_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .hv_det_i(hv), .sda_oe_o(sda_oe)
  );

  typedef struct { string req; logic [7:0] val; } exp_t;
  exp_t       exp_q[$];
  logic [7:0] act_q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // monitor: compare produced results against expected items in order
  always @(negedge clk) begin
    exp_t e;
    logic [7:0] a;
    if (exp_q.size() > 0 && act_q.size() > 0) begin
      e = exp_q.pop_front();
      a = act_q.pop_front();
      n_chk++;
      if (a !== e.val) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", e.req, a, e.val);
      end
    end
  end

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic expect_v(input string r, input logic [7:0] v);
    exp_t e;
    e.req = r; e.val = v;
    exp_q.push_back(e);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; q();
    sda_m = 1'b0; q();
    scl_m = 1'b0; q();
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; q();
    scl_m = 1'b1; q();
    sda_m = 1'b0; q();
    scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q();
    scl_m = 1'b1; q();
    sda_m = 1'b1; q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic nack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q();
      scl_m = 1'b1; q();
      scl_m = 1'b0; q();
    end
    sda_m = 1'b1; q();
    scl_m = 1'b1; q();
    nack = sda_line;
    scl_m = 1'b0; q();
  endtask

  task automatic recv_byte(input logic last, output logic [7:0] b);
    b = '0;
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      q();
      scl_m = 1'b1; q();
      b = {b[6:0], sda_line};
      scl_m = 1'b0;
    end
    sda_m = last; q();
    scl_m = 1'b1; q();
    scl_m = 1'b0; q();
    sda_m = 1'b1;
  endtask

  // driver: send a byte, push expected and observed acknowledge
  task automatic tx_chk(input string r, input logic [7:0] b, input logic exp_nack);
    logic n;
    send_byte(b, n);
    expect_v(r, {7'b0, exp_nack});
    act_q.push_back({7'b0, n});
  endtask

  task automatic mem_write(input string r, input logic [7:0] a, input int n, input logic [7:0] d[3]);
    bus_start();
    tx_chk(r, 8'hA0, 1'b0);
    tx_chk(r, a, 1'b0);
    for (int i = 0; i < n; i++) tx_chk(r, d[i], 1'b0);
    bus_stop();
  endtask

  task automatic mem_read(input string r, input logic [7:0] a, input int n, input logic [7:0] e[3]);
    logic [7:0] b;
    bus_start();
    tx_chk(r, 8'hA0, 1'b0);
    tx_chk(r, a, 1'b0);
    bus_rstart();
    tx_chk(r, 8'hA1, 1'b0);
    for (int i = 0; i < n; i++) begin
      recv_byte(i == n - 1, b);
      expect_v(r, e[i]);
      act_q.push_back(b);
    end
    bus_stop();
  endtask

  task automatic page_sel(input logic p);
    bus_start();
    tx_chk("R4", {6'b011100, p, 1'b0}, 1'b0);
    bus_stop();
  endtask

  task automatic flag_cmd(input string r, input logic [7:0] a, input int nd);
    hv = 1'b1; q();
    bus_start();
    tx_chk(r, a, 1'b0);
    for (int i = 0; i < nd; i++) tx_chk(r, 8'h5C, 1'b0);
    bus_stop();
    q(); hv = 1'b0; q();
  endtask

  task automatic flag_query(input string r, input logic [7:0] a, input logic exp_nack);
    hv = 1'b1; q();
    bus_start();
    tx_chk(r, a, exp_nack);
    bus_stop();
    q(); hv = 1'b0; q();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    q();
    // R10: SDA released after reset
    expect_v("R10", 8'h00);
    act_q.push_back({7'b0, sda_oe});

    // R2 / R3: burst write then random + sequential read
    mem_write("R2", 8'h10, 3, '{8'hA1, 8'hA2, 8'hA3});
    mem_read("R3", 8'h10, 3, '{8'hA1, 8'hA2, 8'hA3});

    // R2: wrap 0xFF -> 0x00 within page 0
    mem_write("R2", 8'hFE, 3, '{8'h11, 8'h22, 8'h33});
    mem_read("R2", 8'hFF, 2, '{8'h22, 8'h33, 8'h00});
    mem_read("R2", 8'h00, 1, '{8'h33, 8'h00, 8'h00});

    // R4 / R5: page 1 distinct from page 0
    page_sel(1'b1);
    mem_write("R4", 8'h10, 1, '{8'h5A, 8'h00, 8'h00});
    mem_write("R4", 8'h90, 1, '{8'h12, 8'h00, 8'h00});
    mem_read("R4", 8'h10, 1, '{8'h5A, 8'h00, 8'h00});
    page_sel(1'b0);
    mem_read("R5", 8'h10, 1, '{8'hA1, 8'h00, 8'h00});

    // R1: unknown device code NoACKed
    bus_start();
    tx_chk("R1", 8'h92, 1'b1);
    bus_stop();

    // R8: flag commands without qualifier are NoACKed
    bus_start();
    tx_chk("R8", 8'h68, 1'b1);
    bus_stop();
    bus_start();
    tx_chk("R8", 8'h61, 1'b1);
    bus_stop();

    // R7 / R9: set block 0, query blocks 0 and 1
    flag_cmd("R7", 8'h68, 2);
    flag_query("R9", 8'h61, 1'b1);
    flag_query("R9", 8'h63, 1'b0);

    // R6: write into block 0 ACKed but ignored; R5: block 1 still writable
    mem_write("R6", 8'h10, 1, '{8'hFF, 8'h00, 8'h00});
    mem_read("R6", 8'h10, 1, '{8'hA1, 8'h00, 8'h00});
    mem_write("R5", 8'h80, 1, '{8'h77, 8'h00, 8'h00});
    mem_read("R5", 8'h80, 1, '{8'h77, 8'h00, 8'h00});

    // R8: qualifier dropped between filler bytes aborts the set
    hv = 1'b1; q();
    bus_start();
    tx_chk("R8", 8'h6A, 1'b0);
    tx_chk("R8", 8'h00, 1'b0);
    hv = 1'b0;
    tx_chk("R8", 8'h00, 1'b0);
    bus_stop();
    q();
    flag_query("R8", 8'h63, 1'b0);

    // R7: only one filler byte -> no commit
    flag_cmd("R7", 8'h6A, 1);
    flag_query("R7", 8'h63, 1'b0);

    // R6 / R5: protect block 3, block 2 of page 1 stays writable
    flag_cmd("R7", 8'h6E, 2);
    page_sel(1'b1);
    mem_write("R6", 8'h90, 1, '{8'hEE, 8'h00, 8'h00});
    mem_read("R6", 8'h90, 1, '{8'h12, 8'h00, 8'h00});
    mem_write("R5", 8'h10, 1, '{8'hC4, 8'h00, 8'h00});
    mem_read("R5", 8'h10, 1, '{8'hC4, 8'h00, 8'h00});
    page_sel(1'b0);

    // R7: clear block 0, write now lands
    flag_cmd("R7", 8'h60, 2);
    flag_query("R9", 8'h61, 1'b0);
    mem_write("R7", 8'h10, 1, '{8'hC3, 8'h00, 8'h00});
    mem_read("R7", 8'h10, 1, '{8'hC3, 8'h00, 8'h00});

    repeat (5) @(negedge clk);
    if (exp_q.size() != 0 || act_q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: actual %0d left expected %0d left", act_q.size(), exp_q.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule